// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block connects a simple synchronous request port to an asynchronous EDO DRAM that takes its address in two halves over shared pins and moves data over an 8-bit bus. A request carries a flat address, a write flag and a write byte. The controller splits the address into a row half and a column half. It drives the active-low row strobe, column strobe, write enable and output enable, and it returns read bytes with a one-cycle valid pulse.

After an access the row stays open. A later request to the same row needs only a new column-strobe cycle. A request to a different row first closes the open row, waits out the precharge count, and then opens the new row. Every write is an early write: write enable goes low one clock before the column strobe falls, and output enable is held high for the whole write, so the memory never drives the bus while the controller does.

An interval counter raises a refresh request. The controller then stops accepting requests, closes any open row and runs a column-before-row refresh. Every delay is a parameter given in clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all four strobes are high, the data bus is not driven, rd_valid_o is low and req_ready_o is high.
- R2: The row strobe falls only after it has been high for at least T_RP cycles, with the row address already on the address pins one cycle earlier and unchanged.
- R3: For an access, the column strobe falls only after the row strobe has been low for at least T_RCD cycles, with the column address present and unchanged from the cycle before.
- R4: A write drives write enable low at least one cycle before the column strobe falls and drives the byte onto the bus at that fall. Output enable stays high whenever write enable is low or the bus is driven.
- R5: A read keeps write enable high and output enable low. rd_valid_o is a single-cycle pulse that comes exactly T_CAS cycles after the cycle in which the column strobe fell, and it carries the byte that was on the bus in the last strobe-low cycle.
- R6: Accesses to the open row cause no row-strobe fall. Only the column strobe cycles.
- R7: An access to a row other than the open one raises the row strobe, keeps it high for at least T_RP cycles, and then opens the new row.
- R8: A refresh takes place at least once in every REF_INT plus 30 cycles. In a refresh the column strobe falls while the row strobe is high, write enable stays high, and afterwards the row is closed, so the next access opens a row again.
- R9: req_ready_o is low whenever the column strobe is low. A request is accepted only on a cycle in which req_valid_i and req_ready_o are both high.
- R10: A read returns the byte most recently written to the same flat address, where the address is {row, column} with the row in the upper ROW_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Flat address {row, column} |
| req_wdata_i | input | DW | Write byte |
| rd_valid_o | output | 1 | Read byte valid, one-cycle pulse |
| rd_data_o | output | DW | Read byte |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_oe_n_o | output | 1 | Output enable, active low |
| dram_dq_o | output | DW | Bus value driven by the controller |
| dram_dq_oe_o | output | 1 | Controller drives the bus |
| dram_dq_i | input | DW | Bus value driven by the memory |

## Verification
If the open-row register disagrees with the memory's latched row, bytes land in the wrong row. The next read of that address then shows a wrong byte within one access. A wrong hit decision also shows at once as an extra or a missing row-strobe fall in a same-row burst. A state machine that is early or late by one count breaks the precharge, row-to-column or latency windows at the very edge where that strobe moves. A stuck refresh timer shows up as a gap between column-before-row events that grows past the allowed bound.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_ROW, ST_RCD, ST_COL, ST_CAS, ST_CP,
    ST_RF_PRE, ST_RF_CAS, ST_RF_RAS, ST_RF_REC
  } st_e;
endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int unsigned REF_INT = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int unsigned W = $clog2(REF_INT + 1);
  logic [W-1:0] cnt_q;
  logic         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= W'(REF_INT - 1);
      pend_q <= 1'b0;
    end else begin
      if (ack_i) pend_q <= 1'b0;
      if (cnt_q == '0) begin
        cnt_q  <= W'(REF_INT - 1);
        pend_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/edo_row_tracker.sv
module edo_row_tracker #(
  parameter int unsigned ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [ROW_W-1:0] look_i,
  output logic             open_o,
  output logic             hit_o
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (close_i) begin
      open_q <= 1'b0;
    end else if (open_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end
  end

  assign open_o = open_q;
  assign hit_o  = open_q && (row_q == look_i);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W     = 4,
  parameter int unsigned COL_W     = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RCD     = 2,
  parameter int unsigned T_CAS     = 2,
  parameter int unsigned T_CP      = 1,
  parameter int unsigned T_RAS_REF = 4,
  parameter int unsigned REF_INT   = 200,
  localparam int unsigned AW   = ROW_W + COL_W,
  localparam int unsigned MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_we_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            rd_valid_o,
  output logic [DW-1:0]   rd_data_o,
  output logic [MA_W-1:0] dram_addr_o,
  output logic            dram_ras_n_o,
  output logic            dram_cas_n_o,
  output logic            dram_we_n_o,
  output logic            dram_oe_n_o,
  output logic [DW-1:0]   dram_dq_o,
  output logic            dram_dq_oe_o,
  input  logic [DW-1:0]   dram_dq_i
);
  localparam int unsigned T_A   = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int unsigned T_B   = (T_CAS > T_CP) ? T_CAS : T_CP;
  localparam int unsigned T_C   = (T_A > T_B) ? T_A : T_B;
  localparam int unsigned TMAX  = (T_C > T_RAS_REF) ? T_C : T_RAS_REF;
  localparam int unsigned CNT_W = $clog2(TMAX + 1);

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [DW-1:0]    wdata_q;
  logic             rd_valid_q;
  logic [DW-1:0]    rd_data_q;

  logic ref_pend, ref_ack, row_open, row_hit, cnt_zero, col_phase, accept;

  assign cnt_zero  = (cnt_q == '0);
  assign col_phase = (st_q == ST_COL) || (st_q == ST_CAS);
  assign ref_ack   = (st_q == ST_RF_CAS);
  assign accept    = req_valid_i && req_ready_o;

  edo_refresh_timer #(.REF_INT(REF_INT)) u_ref (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ack_i (ref_ack),
    .pend_o(ref_pend)
  );

  edo_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (st_q == ST_ROW),
    .close_i((st_q == ST_PRE) || (st_q == ST_RF_CAS)),
    .row_i  (row_q),
    .look_i (req_addr_i[AW-1:COL_W]),
    .open_o (row_open),
    .hit_o  (row_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      wr_q       <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      wdata_q    <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (ref_pend) begin
            if (row_open) begin
              st_q  <= ST_RF_PRE;
              cnt_q <= CNT_W'(T_RP - 1);
            end else begin
              st_q <= ST_RF_CAS;
            end
          end else if (accept) begin
            wr_q    <= req_we_i;
            row_q   <= req_addr_i[AW-1:COL_W];
            col_q   <= req_addr_i[COL_W-1:0];
            wdata_q <= req_wdata_i;
            if (row_hit) begin
              st_q <= ST_COL;
            end else if (row_open) begin
              st_q  <= ST_PRE;
              cnt_q <= CNT_W'(T_RP - 1);
            end else begin
              st_q <= ST_ROW;
            end
          end
        end
        ST_PRE: begin
          if (cnt_zero) st_q <= ST_ROW;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_ROW: begin
          st_q  <= ST_RCD;
          cnt_q <= CNT_W'(T_RCD - 1);
        end
        ST_RCD: begin
          if (cnt_zero) st_q <= ST_COL;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_COL: begin
          st_q  <= ST_CAS;
          cnt_q <= CNT_W'(T_CAS - 1);
        end
        ST_CAS: begin
          if (cnt_zero) begin
            st_q  <= ST_CP;
            cnt_q <= CNT_W'(T_CP - 1);
            if (!wr_q) begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= dram_dq_i;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_CP: begin
          if (cnt_zero) st_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_RF_PRE: begin
          if (cnt_zero) st_q <= ST_RF_CAS;
          else cnt_q <= cnt_q - 1'b1;
        end
        ST_RF_CAS: begin
          st_q  <= ST_RF_RAS;
          cnt_q <= CNT_W'(T_RAS_REF - 1);
        end
        ST_RF_RAS: begin
          if (cnt_zero) begin
            st_q  <= ST_RF_REC;
            cnt_q <= CNT_W'(T_RP - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RF_REC: begin
          if (cnt_zero) st_q <= ST_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      ST_RCD, ST_COL, ST_CAS, ST_CP, ST_RF_RAS: dram_ras_n_o = 1'b0;
      ST_IDLE:                                  dram_ras_n_o = !row_open;
      default:                                  dram_ras_n_o = 1'b1;
    endcase
  end

  assign dram_cas_n_o = !((st_q == ST_CAS) || (st_q == ST_RF_CAS) || (st_q == ST_RF_RAS));
  assign dram_we_n_o  = !(col_phase && wr_q);
  assign dram_oe_n_o  = !(col_phase && !wr_q);
  assign dram_dq_oe_o = col_phase && wr_q;
  assign dram_dq_o    = wdata_q;
  assign dram_addr_o  = (col_phase || st_q == ST_CP) ? MA_W'(col_q) : MA_W'(row_q);
  assign req_ready_o  = (st_q == ST_IDLE) && !ref_pend;
  assign rd_valid_o   = rd_valid_q;
  assign rd_data_o    = rd_data_q;
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int unsigned MA_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            rd_valid_o,
  input logic [MA_W-1:0] dram_addr_o,
  input logic            dram_ras_n_o,
  input logic            dram_cas_n_o,
  input logic            dram_we_n_o,
  input logic            dram_oe_n_o,
  input logic            dram_dq_oe_o
);
  // R2
  ras_fall_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_n_o) |-> $stable(dram_addr_o));
  // R4
  we_oe_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_we_n_o |-> dram_oe_n_o);
  // R4
  bus_drive_oe_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_dq_oe_o |-> (dram_oe_n_o && !dram_we_n_o));
  // R4
  early_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_n_o) && !dram_we_n_o) |-> ($past(dram_we_n_o) == 1'b0));
  // R5
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  // R8
  cbr_we_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_n_o) && dram_ras_n_o) |-> dram_we_n_o);
  // R9
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_n_o |-> !req_ready_o);
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(.MA_W(MA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .rd_valid_o  (rd_valid_o),
  .dram_addr_o (dram_addr_o),
  .dram_ras_n_o(dram_ras_n_o),
  .dram_cas_n_o(dram_cas_n_o),
  .dram_we_n_o (dram_we_n_o),
  .dram_oe_n_o (dram_oe_n_o),
  .dram_dq_oe_o(dram_dq_oe_o)
);

// File: tb/edo_dram_ctrl_bench.sv
`timescale 1ns/1ps
module edo_dram_ctrl_bench;
  localparam int ROW_W = 4, COL_W = 4, DW = 8;
  localparam int T_RP = 3, T_RCD = 2, T_CAS = 2, T_CP = 1, T_RAS_REF = 4, REF_INT = 200;
  localparam int AW = ROW_W + COL_W, MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int N = 1 << AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic [MA_W-1:0] addr;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] dq_o;
  logic [DW-1:0] dq_i = '0;

  always #4 clk = ~clk;

  edo_dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .T_RP(T_RP), .T_RCD(T_RCD),
    .T_CAS(T_CAS), .T_CP(T_CP), .T_RAS_REF(T_RAS_REF), .REF_INT(REF_INT)
  ) u_edo_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .dram_addr_o(addr), .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n),
    .dram_we_n_o(we_n), .dram_oe_n_o(oe_n), .dram_dq_o(dq_o),
    .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  function automatic void chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // behavioural memory and golden host view
  logic [DW-1:0] mem [N];
  logic [DW-1:0] gold[N];
  int exp_q[$];
  int fall_q[$];
  int cyc = 0, ras_hi = 0, ras_lo = 0, opens = 0, cbrs = 0, last_cbr = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1;
  logic [MA_W-1:0] p_addr = '0;
  logic [ROW_W-1:0] row_l = '0;
  logic [COL_W-1:0] col_l = '0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      cyc = 0; ras_hi = 0; ras_lo = 0; last_cbr = 0;
      p_ras = 1; p_cas = 1; p_we = 1;
    end else begin
      cyc++;
      // R4 bus ownership every cycle
      chk(!(dq_oe && !oe_n), "R4 oe high while driving", oe_n, 1);
      chk(we_n || oe_n, "R4 oe high while we low", oe_n, 1);
      // R9
      chk(!(req_ready && !cas_n), "R9 ready while cas low", req_ready, 0);
      if (p_ras && !ras_n) begin
        chk(addr == p_addr, "R2 addr stable at ras fall", addr, p_addr);
        chk(ras_hi >= T_RP, "R2 R7 ras precharge", ras_hi, T_RP);
        if (cas_n) begin
          row_l = addr[ROW_W-1:0];
          opens++;
        end else begin
          cbrs++;
          chk(cyc - last_cbr <= REF_INT + 30, "R8 refresh gap", cyc - last_cbr, REF_INT + 30);
          chk(we_n, "R8 we high in refresh", we_n, 1);
          last_cbr = cyc;
        end
      end
      if (p_cas && !cas_n && !ras_n) begin
        chk(ras_lo >= T_RCD, "R3 ras to cas", ras_lo, T_RCD);
        chk(addr == p_addr, "R3 col addr stable", addr, p_addr);
        col_l = addr[COL_W-1:0];
        if (!we_n) begin
          chk(!p_we, "R4 early write", p_we, 0);
          chk(dq_oe, "R4 data driven", dq_oe, 1);
          mem[{row_l, col_l}] = dq_o;
        end else begin
          chk(!oe_n, "R5 oe low on read", oe_n, 0);
          fall_q.push_back(cyc);
        end
      end
      if (rd_valid) begin
        if (exp_q.size() == 0 || fall_q.size() == 0) begin
          chk(0, "R5 unexpected rd_valid", 1, 0);
        end else begin
          int e, f;
          e = exp_q.pop_front();
          f = fall_q.pop_front();
          chk(cyc == f + T_CAS, "R5 read latency", cyc - f, T_CAS);
          chk(rd_data == e[DW-1:0], "R10 read data", rd_data, e);
        end
      end
      if (req_valid && req_ready) begin
        if (req_we) gold[req_addr] = req_wdata;
        else exp_q.push_back(int'(gold[req_addr]));
      end
      ras_hi = ras_n ? ras_hi + 1 : 0;
      ras_lo = ras_n ? 0 : ras_lo + 1;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = addr;
    end
    dq_i = (!ras_n && !cas_n && we_n && !oe_n) ? mem[{row_l, col_l}] : '0;
  end

  task automatic host(bit w, int a, int d);
    @(posedge clk); #1;
    req_valid = 1; req_we = w; req_addr = AW'(a); req_wdata = DW'(d);
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0) && t < 200) begin @(negedge clk); t++; end
    chk(exp_q.size() == 0, "R5 reads drained", exp_q.size(), 0);
  endtask

  task automatic wait_cbr();
    int c0 = cbrs;
    while (cbrs == c0) @(negedge clk);
    repeat (T_RP + 2) @(negedge clk);
  endtask

  initial begin
    int base;
    int seed;
    for (int i = 0; i < N; i++) begin mem[i] = DW'(i ^ 8'h5a); gold[i] = DW'(i ^ 8'h5a); end
    repeat (3) @(negedge clk);
    // R1
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes high in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !rd_valid, "R1 bus idle in reset", dq_oe, 0);
    @(posedge clk); #1 rst_ni = 1;
    @(negedge clk);
    chk(ras_n && cas_n && req_ready, "R1 idle after reset", {ras_n, cas_n, req_ready}, 7);

    // R10 write then read across rows
    for (int i = 0; i < 16; i++) host(1, i * 17, 8'hc0 + i);
    for (int i = 0; i < 16; i++) host(0, i * 17, 0);
    host(0, 8'h33, 0);  // unwritten
    drain();

    // R6 page hits after a refresh closed the row
    wait_cbr();
    base = opens;
    host(1, 8'h51, 8'h11);
    host(0, 8'h51, 0);
    host(1, 8'h5e, 8'h22);
    host(0, 8'h5e, 0);
    drain();
    chk(opens - base == 1, "R6 one row open for same-row burst", opens - base, 1);
    // R7 page miss
    host(0, 8'h93, 0);
    drain();
    chk(opens - base == 2, "R7 new row opened on miss", opens - base, 2);

    // R8 row reopened after refresh
    wait_cbr();
    base = opens;
    host(0, 8'h93, 0);
    drain();
    chk(opens - base == 1, "R8 row reopened after refresh", opens - base, 1);

    // mixed pattern
    seed = 32'h1234;
    for (int i = 0; i < 80; i++) begin
      seed = seed * 1103515245 + 12345;
      host(seed[20], (seed >> 8) & 8'hff, (seed >> 16) & 8'hff);
    end
    drain();

    repeat (450) @(negedge clk);
    chk(cbrs >= 3, "R8 refreshes occurred", cbrs, 3);
    chk(cyc - last_cbr <= REF_INT + 30, "R8 refresh not stalled", cyc - last_cbr, REF_INT + 30);
    for (int i = 0; i < N; i += 7)
      chk(mem[i] == gold[i], "R10 memory contents", mem[i], gold[i]);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "R9 watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule